// File: doc/BRIEF.md
# External Bus Wait-State Inserter

This block sits in front of the strobe generator of a static external memory controller. It decides whether each new bus access must be preceded by one idle cycle. It keeps a record of the last accepted access, which is its chip select and whether it was a read or a write. Each chip select has its own timing settings: a write-mode bit, hold and setup values for the write and read strobes, a chip-select hold for writes and a chip-select-to-read setup. The block compares the incoming request against the recorded access and these settings.

Requests arrive on a valid/ready handshake. When a wait cycle is needed, the block holds `req_ready` low for the first cycle of the request. In the next cycle it raises the registered `ws_insert` for exactly one cycle, together with a cause code. In that same cycle the request is accepted. When the cause is an early read, `hold_outputs` tells the pin logic to keep the address, data, chip-select and byte-select lines at their write values for that extra cycle.

Top module: `ext_ws_inserter`

## Requirements
- R1: After reset no access is recorded, so the first accepted request of either type on any chip select is accepted without a wait cycle.
- R2: A request on a chip select different from the recorded one gets one wait cycle with cause code 2'b01.
- R3: The chip-select-change wait has priority over every other cause. A write on one select followed by a read on another gets cause 2'b01 and only one wait cycle, even when the early-read conditions hold for the new select.
- R4: A write followed by a read on the same select gets one wait cycle with cause 2'b10 when that select's write-strobe hold and read-strobe setup are both zero.
- R5: With write-mode bit 0 (write controlled by chip select), a same-select write then read gets cause 2'b10 when the chip-select write hold and the chip-select-to-read setup are both zero, whatever the read-strobe setup is.
- R6: With write-mode bit 1 (write controlled by the write strobe), a same-select write then read gets cause 2'b10 when the write-strobe hold is zero.
- R7: A same-select write then read for which none of the conditions of R4 to R6 holds is accepted without a wait cycle.
- R8: A read followed by a write on the same select gets one wait cycle with cause 2'b11.
- R9: Two consecutive reads, or two consecutive writes, on the same select are accepted without a wait cycle.
- R10: A waiting request sees `req_ready` low in its first cycle. `ws_insert` is high in the following cycle only, and in that cycle `req_ready` is high.
- R11: `hold_outputs` is high only in an early-read wait cycle (cause 2'b10).
- R12: Cause encoding is 2'b00 none, 2'b01 chip-select change, 2'b10 early read, 2'b11 read-to-write. `ws_cause` is 2'b00 whenever `ws_insert` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New access request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_cs | input | CSW | Chip select of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_wr_mode | input | NUM_CS | Per-select write-mode bit (0 chip-select controlled, 1 write-strobe controlled) |
| cfg_we_hold | input | NUM_CS*TW | Per-select write-strobe hold |
| cfg_rd_setup | input | NUM_CS*TW | Per-select read-strobe setup |
| cfg_cs_wr_hold | input | NUM_CS*TW | Per-select chip-select hold for writes |
| cfg_cs_rd_setup | input | NUM_CS*TW | Per-select chip-select-to-read setup |
| ws_insert | output | 1 | Registered, high during a wait cycle |
| ws_cause | output | 2 | Registered cause of the current wait cycle |
| hold_outputs | output | 1 | Registered, keep write-phase pin values this cycle |

## Verification
The bench sweeps every pair of consecutive accesses over four selects and both access types, under all 32 combinations of zero and non-zero timing fields. It checks the ready timing, the cause and the hold flag of each access. A design that stacks an early-read cycle on a chip-select change fails the cross-select write-to-read cases with a second stall or a wrong cause. A design that ANDs the early-read conditions instead of ORing them misses R5 and R6 cases, and one that ignores the write-mode bit gets R5 and R6 confused. A reset in the middle of a run catches a history that survives reset, which would stall the first access.

// File: rtl/ext_ws_pkg.sv
package ext_ws_pkg;
  typedef enum logic [1:0] {
    WS_NONE     = 2'b00,
    WS_CS_CHG   = 2'b01,
    WS_EARLY_RD = 2'b10,
    WS_RD_TO_WR = 2'b11
  } ws_cause_e;
endpackage

// File: rtl/ws_cfg_sel.sv
module ws_cfg_sel #(
  parameter int NUM_CS = 4,
  parameter int TW     = 6,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CSW-1:0]       sel,
  input  logic [NUM_CS-1:0]    wr_mode_v,
  input  logic [NUM_CS*TW-1:0] we_hold_v,
  input  logic [NUM_CS*TW-1:0] rd_setup_v,
  input  logic [NUM_CS*TW-1:0] cs_wr_hold_v,
  input  logic [NUM_CS*TW-1:0] cs_rd_setup_v,
  output logic                 wr_mode,
  output logic [TW-1:0]        we_hold,
  output logic [TW-1:0]        rd_setup,
  output logic [TW-1:0]        cs_wr_hold,
  output logic [TW-1:0]        cs_rd_setup
);
  logic [TW-1:0] we_hold_a     [NUM_CS];
  logic [TW-1:0] rd_setup_a    [NUM_CS];
  logic [TW-1:0] cs_wr_hold_a  [NUM_CS];
  logic [TW-1:0] cs_rd_setup_a [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign we_hold_a[g]     = we_hold_v[g*TW +: TW];
    assign rd_setup_a[g]    = rd_setup_v[g*TW +: TW];
    assign cs_wr_hold_a[g]  = cs_wr_hold_v[g*TW +: TW];
    assign cs_rd_setup_a[g] = cs_rd_setup_v[g*TW +: TW];
  end

  always_comb begin
    wr_mode     = 1'b0;
    we_hold     = '0;
    rd_setup    = '0;
    cs_wr_hold  = '0;
    cs_rd_setup = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == CSW'(i)) begin
        wr_mode     = wr_mode_v[i];
        we_hold     = we_hold_a[i];
        rd_setup    = rd_setup_a[i];
        cs_wr_hold  = cs_wr_hold_a[i];
        cs_rd_setup = cs_rd_setup_a[i];
      end
    end
  end
endmodule

// File: rtl/ws_history.sv
module ws_history #(
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [CSW-1:0] new_cs,
  input  logic           new_write,
  output logic           prev_valid,
  output logic [CSW-1:0] prev_cs,
  output logic           prev_write
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_cs    <= '0;
      prev_write <= 1'b0;
    end else if (upd) begin
      prev_valid <= 1'b1;
      prev_cs    <= new_cs;
      prev_write <= new_write;
    end
  end
endmodule

// File: rtl/ws_decide.sv
module ws_decide
  import ext_ws_pkg::*;
#(
  parameter int CSW = 2,
  parameter int TW  = 6
) (
  input  logic           prev_valid,
  input  logic [CSW-1:0] prev_cs,
  input  logic           prev_write,
  input  logic [CSW-1:0] new_cs,
  input  logic           new_write,
  input  logic           wr_mode,
  input  logic [TW-1:0]  we_hold,
  input  logic [TW-1:0]  rd_setup,
  input  logic [TW-1:0]  cs_wr_hold,
  input  logic [TW-1:0]  cs_rd_setup,
  output ws_cause_e      cause
);
  logic strobe_gap0, cs_mode_gap0, we_mode_gap0, early_rd;

  always_comb begin
    strobe_gap0  = (we_hold == '0) && (rd_setup == '0);
    cs_mode_gap0 = !wr_mode && (cs_wr_hold == '0) && (cs_rd_setup == '0);
    we_mode_gap0 = wr_mode && (we_hold == '0);
    early_rd     = strobe_gap0 || cs_mode_gap0 || we_mode_gap0;

    cause = WS_NONE;
    if (prev_valid) begin
      if (prev_cs != new_cs)
        cause = WS_CS_CHG;
      else if (prev_write && !new_write && early_rd)
        cause = WS_EARLY_RD;
      else if (!prev_write && new_write)
        cause = WS_RD_TO_WR;
    end
  end
endmodule

// File: rtl/ext_ws_inserter.sv
module ext_ws_inserter
  import ext_ws_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int TW     = 6,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CSW-1:0]       req_cs,
  input  logic                 req_write,
  input  logic [NUM_CS-1:0]    cfg_wr_mode,
  input  logic [NUM_CS*TW-1:0] cfg_we_hold,
  input  logic [NUM_CS*TW-1:0] cfg_rd_setup,
  input  logic [NUM_CS*TW-1:0] cfg_cs_wr_hold,
  input  logic [NUM_CS*TW-1:0] cfg_cs_rd_setup,
  output logic                 ws_insert,
  output logic [1:0]           ws_cause,
  output logic                 hold_outputs
);
  logic           sel_mode;
  logic [TW-1:0]  sel_we_hold, sel_rd_setup, sel_cs_wr_hold, sel_cs_rd_setup;
  logic           prev_valid, prev_write;
  logic [CSW-1:0] prev_cs;
  ws_cause_e      cause;
  logic           need_wait, accept;
  logic           ins_q, hold_q;
  ws_cause_e      cause_q;

  ws_cfg_sel #(.NUM_CS(NUM_CS), .TW(TW)) u_sel (
    .sel(req_cs), .wr_mode_v(cfg_wr_mode), .we_hold_v(cfg_we_hold),
    .rd_setup_v(cfg_rd_setup), .cs_wr_hold_v(cfg_cs_wr_hold),
    .cs_rd_setup_v(cfg_cs_rd_setup), .wr_mode(sel_mode),
    .we_hold(sel_we_hold), .rd_setup(sel_rd_setup),
    .cs_wr_hold(sel_cs_wr_hold), .cs_rd_setup(sel_cs_rd_setup)
  );

  ws_history #(.CSW(CSW)) u_hist (
    .clk(clk), .rst(rst), .upd(accept), .new_cs(req_cs),
    .new_write(req_write), .prev_valid(prev_valid), .prev_cs(prev_cs),
    .prev_write(prev_write)
  );

  ws_decide #(.CSW(CSW), .TW(TW)) u_dec (
    .prev_valid(prev_valid), .prev_cs(prev_cs), .prev_write(prev_write),
    .new_cs(req_cs), .new_write(req_write), .wr_mode(sel_mode),
    .we_hold(sel_we_hold), .rd_setup(sel_rd_setup),
    .cs_wr_hold(sel_cs_wr_hold), .cs_rd_setup(sel_cs_rd_setup),
    .cause(cause)
  );

  assign need_wait = (cause != WS_NONE);
  assign req_ready = !need_wait || ins_q;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q   <= 1'b0;
      cause_q <= WS_NONE;
      hold_q  <= 1'b0;
    end else if (req_valid && need_wait && !ins_q) begin
      ins_q   <= 1'b1;
      cause_q <= cause;
      hold_q  <= (cause == WS_EARLY_RD);
    end else begin
      ins_q   <= 1'b0;
      cause_q <= WS_NONE;
      hold_q  <= 1'b0;
    end
  end

  assign ws_insert    = ins_q;
  assign ws_cause     = cause_q;
  assign hold_outputs = hold_q;
endmodule

// File: rtl/ws_inserter_chk.sv
module ws_inserter_chk #(
  parameter int CSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [CSW-1:0] req_cs,
  input logic           ws_insert,
  input logic [1:0]     ws_cause,
  input logic           hold_outputs
);
  logic           seen_q;
  logic [CSW-1:0] last_cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      last_cs_q <= '0;
    end else if (req_valid && req_ready) begin
      seen_q    <= 1'b1;
      last_cs_q <= req_cs;
    end
  end

  // R10
  single_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ws_insert |=> !ws_insert);

  // R10
  stall_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> ws_insert);

  // R10
  ready_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ws_insert |-> req_ready);

  // R11
  hold_only_early_chk: assert property (@(posedge clk) disable iff (rst)
    hold_outputs |-> (ws_insert && ws_cause == 2'b10));

  // R12
  idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !ws_insert |-> (ws_cause == 2'b00));

  // R1
  first_free_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seen_q) |-> req_ready);

  // R2
  cs_change_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seen_q && req_cs != last_cs_q && !ws_insert) |-> !req_ready);
endmodule

bind ext_ws_inserter ws_inserter_chk #(.CSW(CSW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_cs(req_cs), .ws_insert(ws_insert), .ws_cause(ws_cause),
  .hold_outputs(hold_outputs)
);

// File: tb/sim_ext_ws_inserter.sv
module sim_ext_ws_inserter;
  localparam int NCS = 4;
  localparam int TW  = 2;
  localparam int CSW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CSW-1:0] req_cs = '0;
  logic req_write = 1'b0;
  logic [NCS-1:0]    cfg_wr_mode = '0;
  logic [NCS*TW-1:0] cfg_we_hold = '0, cfg_rd_setup = '0;
  logic [NCS*TW-1:0] cfg_cs_wr_hold = '0, cfg_cs_rd_setup = '0;
  logic ws_insert, hold_outputs;
  logic [1:0] ws_cause;

  int n_chk = 0, n_bad = 0;
  int cfg_of [NCS];
  bit m_valid = 0, m_wr = 0;
  int m_cs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_ws_inserter #(.NUM_CS(NCS), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_write(req_write), .cfg_wr_mode(cfg_wr_mode),
    .cfg_we_hold(cfg_we_hold), .cfg_rd_setup(cfg_rd_setup),
    .cfg_cs_wr_hold(cfg_cs_wr_hold), .cfg_cs_rd_setup(cfg_cs_rd_setup),
    .ws_insert(ws_insert), .ws_cause(ws_cause), .hold_outputs(hold_outputs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // combo bits: 0 mode, 1 we_hold!=0, 2 rd_setup!=0, 3 cs_wr_hold!=0, 4 cs_rd_setup!=0
  function automatic int which_early(input int c);
    if (!c[1] && !c[2]) return 4;
    if (!c[0] && !c[3] && !c[4]) return 5;
    if (c[0] && !c[1]) return 6;
    return 0;
  endfunction

  task automatic load_cfg(input int base);
    for (int k = 0; k < NCS; k++) begin
      int c;
      c = (base + k * 5) % 32;
      cfg_of[k] = c;
      cfg_wr_mode[k] = c[0];
      cfg_we_hold[k*TW +: TW]     = c[1] ? TW'(1 + k % 3) : '0;
      cfg_rd_setup[k*TW +: TW]    = c[2] ? TW'(3) : '0;
      cfg_cs_wr_hold[k*TW +: TW]  = c[3] ? TW'(2) : '0;
      cfg_cs_rd_setup[k*TW +: TW] = c[4] ? TW'(1) : '0;
    end
  endtask

  task automatic access(input int cs, input bit wr);
    int exp; string tag; int e;
    exp = 0; tag = "R9";
    e = which_early(cfg_of[cs]);
    if (!m_valid) tag = "R1";
    else if (m_cs != cs) begin exp = 1; tag = (m_wr && !wr && e != 0) ? "R3" : "R2"; end
    else if (m_wr && !wr) begin
      if (e == 4) begin exp = 2; tag = "R4"; end
      else if (e == 5) begin exp = 2; tag = "R5"; end
      else if (e == 6) begin exp = 2; tag = "R6"; end
      else tag = "R7";
    end else if (!m_wr && wr) begin exp = 3; tag = "R8"; end
    @(negedge clk);
    req_valid = 1'b1; req_cs = CSW'(cs); req_write = wr;
    #1;
    chk(req_ready == (exp == 0), {tag, " R10 ready"}, int'(req_ready), int'(exp == 0));
    @(negedge clk);
    if (exp != 0) begin
      chk(ws_insert == 1'b1, {tag, " R10 insert"}, int'(ws_insert), 1);
      chk(ws_cause == 2'(exp), {tag, " R12 cause"}, int'(ws_cause), exp);
      chk(hold_outputs == (exp == 2), {tag, " R11 hold"}, int'(hold_outputs), int'(exp == 2));
      chk(req_ready == 1'b1, {tag, " R10 ready in wait"}, int'(req_ready), 1);
      @(negedge clk);
    end
    chk(ws_insert == 1'b0 && ws_cause == 2'b00, {tag, " R10 one cycle"}, int'(ws_insert), 0);
    req_valid = 1'b0;
    m_valid = 1; m_cs = cs; m_wr = wr;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    load_cfg(0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(ws_insert == 0 && ws_cause == 0 && hold_outputs == 0, "R12 reset state",
        int'(ws_insert), 0);
    access(2, 1'b1);
    access(2, 1'b0);
    // reset mid-run: history must be forgotten (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_valid = 0;
    access(1, 1'b1);
    for (int combo = 0; combo < 32; combo++) begin
      load_cfg(combo);
      for (int p = 0; p < 2 * NCS; p++)
        for (int q = 0; q < 2 * NCS; q++) begin
          access(p / 2, p[0]);
          access(q / 2, q[0]);
        end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule